// File: doc/BRIEF.md
# Multi-Precision Packed Dot-Product Accumulate Unit

This execute-stage datapath takes two 32-bit words that each hold packed integer lanes. It multiplies matching lanes, adds every product together, and adds that total to a 32-bit accumulator. The result is registered and appears one cycle after issue. Lanes can be 8, 4 or 2 bits wide. A per-operation flag chooses whether lanes are treated as two's complement or as unsigned values. The same mode applies to both operands.

A four-entry weight register file sits beside the datapath. In the fused mode, the first operand is taken from a weight entry rather than from the general-purpose input. In the same cycle, the data returned by a concurrent memory load is written into a chosen entry. One instruction therefore performs both the load and the multiply-accumulate. In the plain mode, both operands come from the general-purpose inputs and the weight file is left alone.

Top module: `simd_dotp_unit`

## Requirements
- R1: After reset, `result_o` is 0, `valid_o` is 0, and all four weight entries hold 0.
- R2: `valid_o` is 1 in the cycle after a cycle with `issue_i` high, and 0 otherwise. When no operation is issued, `result_o` keeps its previous value.
- R3: When `width_i` is 0 or 3, the lanes are four 8-bit fields. Lane i occupies bits [8i+7:8i].
- R4: When `width_i` is 1, the lanes are eight 4-bit fields. Lane i occupies bits [4i+3:4i].
- R5: When `width_i` is 2, the lanes are sixteen 2-bit fields. Lane i occupies bits [2i+1:2i].
- R6: When `sign_i` is 1, every lane of both operands is sign-extended before multiplication. When it is 0, every lane is zero-extended.
- R7: `result_o` equals `acc_i` plus the sum of all lane products, modulo 2^32, with no saturation.
- R8: When `fused_i` is 1, the first operand is weight entry `rsel_i` and `opa_i` has no effect.
- R9: A fused issue writes `ld_data_i` into entry `ld_idx_i`. If that entry is also the one being read in the same cycle, the read returns the old value.
- R10: A plain issue (`fused_i` 0) leaves every weight entry unchanged, whatever is on the load inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Start an operation this cycle |
| fused_i | input | 1 | 1: take weight from the file and write load data; 0: plain mode |
| width_i | input | 2 | Lane width: 0 or 3 = 8-bit, 1 = 4-bit, 2 = 2-bit |
| sign_i | input | 1 | 1: signed lanes, 0: unsigned lanes |
| opa_i | input | 32 | First operand in plain mode |
| opb_i | input | 32 | Second operand |
| acc_i | input | 32 | Accumulator addend |
| rsel_i | input | 2 | Weight entry read in fused mode |
| ld_idx_i | input | 2 | Weight entry written in fused mode |
| ld_data_i | input | 32 | Load data written in fused mode |
| result_o | output | 32 | Registered sum-of-products result |
| valid_o | output | 1 | Result produced by the previous cycle's issue |

## Verification
The assertions take for granted that the load inputs carry meaningful data only when a fused issue is made. They also assume that an operation with an all-zero second operand must return the accumulator unchanged. The stimulus follows these rules: the load inputs are set to garbage during plain issues and idle cycles, and directed cases with a zero second operand are included.

The scoreboard keeps its own copy of the weight file. It uses this copy to predict every fused read, including reads of an entry that is overwritten in the same cycle. Plain issues with non-zero load inputs are later followed by fused reads of the affected entries, which shows at the ports that those entries were not changed.

// File: rtl/simd_dotp_unit.sv
module simd_dotp_unit #(
  parameter int XLEN  = 32,
  parameter int NWREG = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     issue_i,
  input  logic                     fused_i,
  input  logic [1:0]               width_i,
  input  logic                     sign_i,
  input  logic [XLEN-1:0]          opa_i,
  input  logic [XLEN-1:0]          opb_i,
  input  logic [XLEN-1:0]          acc_i,
  input  logic [$clog2(NWREG)-1:0] rsel_i,
  input  logic [$clog2(NWREG)-1:0] ld_idx_i,
  input  logic [XLEN-1:0]          ld_data_i,
  output logic [XLEN-1:0]          result_o,
  output logic                     valid_o
);
  localparam int N8 = XLEN / 8;
  localparam int N4 = XLEN / 4;
  localparam int N2 = XLEN / 2;

  logic [NWREG-1:0][XLEN-1:0] wreg;
  logic [XLEN-1:0] a_op;
  logic [XLEN-1:0] sum8, sum4, sum2, dot;

  assign a_op = fused_i ? wreg[rsel_i] : opa_i;

  always_comb begin
    logic signed [8:0]  ea8, eb8;
    logic signed [17:0] p8;
    sum8 = '0;
    for (int i = 0; i < N8; i++) begin
      ea8  = $signed({sign_i & a_op[8*i+7], a_op[8*i +: 8]});
      eb8  = $signed({sign_i & opb_i[8*i+7], opb_i[8*i +: 8]});
      p8   = ea8 * eb8;
      sum8 = sum8 + XLEN'(p8);
    end
  end

  always_comb begin
    logic signed [4:0] ea4, eb4;
    logic signed [9:0] p4;
    sum4 = '0;
    for (int i = 0; i < N4; i++) begin
      ea4  = $signed({sign_i & a_op[4*i+3], a_op[4*i +: 4]});
      eb4  = $signed({sign_i & opb_i[4*i+3], opb_i[4*i +: 4]});
      p4   = ea4 * eb4;
      sum4 = sum4 + XLEN'(p4);
    end
  end

  always_comb begin
    logic signed [2:0] ea2, eb2;
    logic signed [5:0] p2;
    sum2 = '0;
    for (int i = 0; i < N2; i++) begin
      ea2  = $signed({sign_i & a_op[2*i+1], a_op[2*i +: 2]});
      eb2  = $signed({sign_i & opb_i[2*i+1], opb_i[2*i +: 2]});
      p2   = ea2 * eb2;
      sum2 = sum2 + XLEN'(p2);
    end
  end

  always_comb begin
    unique case (width_i)
      2'd1:    dot = sum4;
      2'd2:    dot = sum2;
      default: dot = sum8;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= issue_i;
      if (issue_i) result_o <= acc_i + dot;
    end
  end

  for (genvar g = 0; g < NWREG; g++) begin : g_wreg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        wreg[g] <= '0;
      else if (issue_i && fused_i && ld_idx_i == g)
        wreg[g] <= ld_data_i;
    end
  end
endmodule

// File: rtl/simd_dotp_unit_chk.sv
module simd_dotp_unit_chk #(
  parameter int XLEN  = 32,
  parameter int NWREG = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     issue_i,
  input logic                     fused_i,
  input logic [XLEN-1:0]          opb_i,
  input logic [XLEN-1:0]          acc_i,
  input logic [$clog2(NWREG)-1:0] ld_idx_i,
  input logic [XLEN-1:0]          ld_data_i,
  input logic [XLEN-1:0]          result_o,
  input logic                     valid_o,
  input logic [NWREG-1:0][XLEN-1:0] wreg
);
  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> valid_o);
  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> !valid_o);
  // R2
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(result_o));
  // R7
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && opb_i == '0) |=> result_o == $past(acc_i));
  // R9
  fused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && fused_i) |=> wreg[$past(ld_idx_i)] == $past(ld_data_i));
  // R10
  plain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(issue_i && fused_i) |=> $stable(wreg));
endmodule

bind simd_dotp_unit simd_dotp_unit_chk #(.XLEN(XLEN), .NWREG(NWREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .fused_i(fused_i),
  .opb_i(opb_i), .acc_i(acc_i), .ld_idx_i(ld_idx_i), .ld_data_i(ld_data_i),
  .result_o(result_o), .valid_o(valid_o), .wreg(wreg)
);

// File: tb/sim_simd_dotp_unit.sv
module sim_simd_dotp_unit;
  logic clk = 0, rst_n = 0;
  logic issue_i = 0, fused_i = 0, sign_i = 0;
  logic [1:0] width_i = 0, rsel_i = 0, ld_idx_i = 0;
  logic [31:0] opa_i = 0, opb_i = 0, acc_i = 0, ld_data_i = 0;
  logic [31:0] result_o;
  logic valid_o;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic [31:0] model_rf[4];
  logic [31:0] last_res = 0;

  always #2 clk = ~clk;

  simd_dotp_unit u0 (.*);

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b,
                                        logic [31:0] acc, logic [1:0] w, logic s);
    int lw, n, sum, va, vb;
    lw = (w == 2'd1) ? 4 : (w == 2'd2) ? 2 : 8;
    n = 32 / lw;
    sum = 0;
    for (int i = 0; i < n; i++) begin
      va = int'((a >> (i*lw)) & ((32'd1 << lw) - 1));
      vb = int'((b >> (i*lw)) & ((32'd1 << lw) - 1));
      if (s && va >= (1 << (lw-1))) va -= (1 << lw);
      if (s && vb >= (1 << (lw-1))) vb -= (1 << lw);
      sum += va * vb;
    end
    return acc + 32'(sum);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(string tag, logic f, logic [1:0] w, logic s, logic [31:0] a,
                    logic [31:0] b, logic [31:0] acc, logic [1:0] rs,
                    logic [1:0] li, logic [31:0] ld);
    logic [31:0] aa;
    @(negedge clk);
    issue_i = 1; fused_i = f; width_i = w; sign_i = s; opa_i = a; opb_i = b;
    acc_i = acc; rsel_i = rs; ld_idx_i = li; ld_data_i = ld;
    aa = f ? model_rf[rs] : a;
    exp_q.push_back(model(aa, b, acc, w, s));
    tag_q.push_back(tag);
    if (f) model_rf[li] = ld;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      issue_i = 0; ld_data_i = 32'hDEAD_BEEF; opa_i = 32'h1234_5678;
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected valid actual=1 expected=0");
      end else begin
        string t;
        t = tag_q.pop_front();
        check(t, result_o, exp_q.pop_front());
        last_res = result_o;
      end
    end else if (issue_i == 0) begin
      check("R2 hold", result_o, last_res);
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) model_rf[i] = 0;
    #5;
    check("R1 result", result_o, 0);
    check("R1 valid", {31'd0, valid_o}, 0);
    @(negedge clk); rst_n = 1;
    // R1: weight entries start at zero, fused reads give acc only
    for (int i = 0; i < 4; i++)
      op("R1 wreg zero", 1, 0, 1, 32'hFFFF_FFFF, 32'h0102_0304, 32'd77, 2'(i), 2'(i), 32'h0);
    // R3 8-bit unsigned and signed
    op("R3 u8", 0, 0, 0, 32'h80FF_0102, 32'hFF80_0304, 32'd5, 0, 0, 0);
    op("R6 s8", 0, 0, 1, 32'h80FF_0102, 32'hFF80_0304, 32'd5, 0, 0, 0);
    op("R3 code3", 0, 3, 1, 32'h7F80_7F80, 32'h7F80_807F, 32'd0, 0, 0, 0);
    // R4 nibbles
    op("R4 u4", 0, 1, 0, 32'hF0E1_D2C3, 32'h8765_4321, 32'd100, 0, 0, 0);
    op("R6 s4", 0, 1, 1, 32'hF0E1_D2C3, 32'h8765_4321, 32'd100, 0, 0, 0);
    op("R4 s4 min", 0, 1, 1, 32'h8888_8888, 32'h8888_8888, 32'd0, 0, 0, 0);
    // R5 crumbs
    op("R5 u2", 0, 2, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 0, 0, 0);
    op("R6 s2", 0, 2, 1, 32'hFFFF_FFFF, 32'hAAAA_AAAA, 32'd0, 0, 0, 0);
    op("R5 s2 mix", 0, 2, 1, 32'h1B1B_E4E4, 32'h6C93_39C6, 32'd9, 0, 0, 0);
    // R7 wrap and zero operand
    op("R7 wrap", 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFF0, 0, 0, 0);
    op("R7 zero b", 0, 0, 1, 32'hDEAD_BEEF, 32'h0, 32'hCAFE_F00D, 0, 0, 0);
    idle(3);
    // R9 fills; R8 fused ignores opa
    op("R9 fill0", 1, 0, 1, 32'hAAAA_5555, 32'h1, 32'd0, 0, 0, 32'h0102_03FD);
    op("R9 fill1", 1, 0, 1, 32'h0, 32'h1, 32'd0, 0, 1, 32'hF7F6_F5F4);
    op("R8 read0", 1, 0, 1, 32'h7F7F_7F7F, 32'h0203_0405, 32'd1, 0, 2, 32'h1111_2222);
    op("R8 read1 4b", 1, 1, 1, 32'h1234_5678, 32'h9ABC_DEF0, 32'd2, 1, 3, 32'h3333_4444);
    // R9 same-cycle read/write of same entry returns old
    op("R9 rw same", 1, 0, 0, 32'h0, 32'h0101_0101, 32'd0, 2, 2, 32'h0505_0505);
    op("R9 new val", 1, 0, 0, 32'h0, 32'h0101_0101, 32'd0, 2, 3, 32'h0);
    // R10 plain issues with load inputs must not touch file
    op("R10 plain", 0, 2, 0, 32'h5555_5555, 32'h5555_5555, 32'd3, 0, 0, 32'hFFFF_FFFF);
    op("R10 plain2", 0, 1, 1, 32'h1111_1111, 32'h2222_2222, 32'd4, 0, 1, 32'hFFFF_FFFF);
    op("R10 keep0", 1, 2, 1, 32'h0, 32'hFFFF_FFFF, 32'd0, 0, 3, 32'h0);
    op("R10 keep1", 1, 2, 0, 32'h0, 32'h5A5A_A5A5, 32'd0, 1, 3, 32'h0);
    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 pending actual=%0d expected=0", exp_q.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule